// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This block observes the per-element results of a vector loop. When an element fails a test, it cuts the active vector length. The loop sequencer opens a loop with a start pulse that carries the initial length. It then presents one element per cycle with that element's index and status. For each element, the unit answers in the same cycle: whether the result may be written, whether the loop must stop at this element, and whether an exception has to be raised as an ordinary fault. The shortened length is registered, and it appears on the length output from the next clock edge onward.

There are two variants, chosen per loop by a mode input.

- **Memory-access variant.** The element's fault flag decides.
  - A fault on the first element is an ordinary exception.
  - A fault on any later element is swallowed, and the length is cut to the number of elements before it.
- **Condition variant.** One bit, picked from the element's 4-bit condition field, is compared with an invert flag.
  - A match ends the loop.
  - An inclusive option keeps the failing element in the new length.
  - A result-suppress option blocks every result write, so that only condition fields are produced.

Top module: `ff_trunc_unit`

## Requirements
- R1: In the memory-access variant (mode input = 1), a fault on element index 0 drives the exception output high for that cycle. Stop stays low, store-enable stays low, and the length is unchanged.
- R2: In the memory-access variant, a fault on element index k ≥ 1 raises stop and keeps exception and store-enable low. From the next edge the length reads k. A non-faulting element raises store-enable.
- R3: The memory-access variant ignores the inclusive flag and never changes the length to zero.
- R4: In the condition variant (mode input = 0), the tested bit is cond_field[bit_sel], where bit_sel = 0 selects the least significant bit. The element fails when the tested bit equals the invert input, and stop is then high for that element.
- R5: On a condition failure, the new length is the failing index plus one when the inclusive flag is set and suppress is clear. Otherwise it is the failing index. The failing element's store-enable is high only in the inclusive case.
- R6: A condition failure on element 0 with the inclusive flag clear sets the length to zero. No later element of that loop produces any output.
- R7: With the suppress flag set in the condition variant, store-enable is low for every element, whether it passes or fails.
- R8: With the suppress flag set, the inclusive flag has no effect on the new length.
- R9: A passing condition element raises store-enable (when suppress is clear). A loop in which no element fails keeps the length loaded at its start.
- R10: After reset the length output reads 0. A start pulse loads the initial length, visible from the next edge. A stop changes the length output at the next edge, and the length output changes at no other time.
- R11: Elements presented after a stop, elements with index ≥ the current length, and elements presented in the cycle of a start pulse produce no store-enable, stop or exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_start | input | 1 | Opens a new loop and loads vl_init |
| vl_init | input | VL_W | Initial vector length of the loop |
| ldst_mode | input | 1 | 1 = memory-access variant, 0 = condition variant |
| elem_valid | input | 1 | An element is presented this cycle |
| elem_idx | input | IDX_W | Index of the presented element |
| elem_fault | input | 1 | Element would raise an exception (memory-access variant) |
| cond_field | input | CR_W | Condition field of the element |
| bit_sel | input | SEL_W | Selects the tested bit of cond_field |
| invert | input | 1 | Failure value of the tested bit |
| inclusive | input | 1 | Keep the failing element in the new length |
| suppress | input | 1 | Block all result writes; only condition fields are written |
| vl_o | output | VL_W | Current (possibly truncated) vector length |
| stop_o | output | 1 | The loop ends at this element |
| store_en_o | output | 1 | The element's result may be written |
| exc_o | output | 1 | Raise an ordinary exception for this element |

## Verification
The bench builds the unit with MAX_VL = 8 and a 4-bit condition field. At that size, loops that run the full length and elements whose index equals the length fit into a few cycles, and every tested bit position can be chosen. Runs cover a fault on the first element, a fault in the middle of a loop, a failure on the first element that leaves a zero length, and the inclusive flag combined with and without suppression. Each loop checks that elements arriving after a stop, and elements past the length, stay silent.

// File: rtl/ff_trunc_pkg.sv
package ff_trunc_pkg;

    typedef enum logic {
        VAR_COND = 1'b0,
        VAR_LDST = 1'b1
    } variant_e;

    // Per-element decision produced by either test path
    typedef struct packed {
        logic fail;   // loop ends at this element
        logic keep;   // element result may be written
        logic exc;    // ordinary exception raised
        logic incl;   // failing element counts in the new length
    } verdict_t;

endpackage

// File: rtl/ff_cond_test.sv
module ff_cond_test
    import ff_trunc_pkg::*;
#(
    parameter int CR_W  = 4,
    parameter int SEL_W = (CR_W > 1) ? $clog2(CR_W) : 1
) (
    input  logic [CR_W-1:0]  cond_field,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             invert,
    input  logic             inclusive,
    input  logic             suppress,
    output verdict_t         verdict
);

    logic tested_bit;
    logic incl_eff;

    always_comb begin
        tested_bit = cond_field[bit_sel];
        // inclusion is only honoured when result writes are enabled
        incl_eff   = inclusive && !suppress;
        verdict.fail = (tested_bit == invert);
        verdict.incl = incl_eff;
        verdict.exc  = 1'b0;
        verdict.keep = !suppress && (!verdict.fail || incl_eff);
    end

endmodule

// File: rtl/ff_ldst_check.sv
module ff_ldst_check
    import ff_trunc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] elem_idx,
    input  logic             elem_fault,
    output verdict_t         verdict
);

    logic first_elem;

    always_comb begin
        first_elem   = (elem_idx == '0);
        verdict.exc  = elem_fault && first_elem;
        verdict.fail = elem_fault && !first_elem;
        verdict.keep = !elem_fault;
        verdict.incl = 1'b0;
    end

endmodule

// File: rtl/ff_trunc_unit.sv
module ff_trunc_unit
    import ff_trunc_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int CR_W   = 4,
    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int SEL_W = (CR_W > 1) ? $clog2(CR_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_start,
    input  logic [VL_W-1:0]  vl_init,
    input  logic             ldst_mode,
    input  logic             elem_valid,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic             elem_fault,
    input  logic [CR_W-1:0]  cond_field,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             invert,
    input  logic             inclusive,
    input  logic             suppress,
    output logic [VL_W-1:0]  vl_o,
    output logic             stop_o,
    output logic             store_en_o,
    output logic             exc_o
);

    typedef struct packed {
        logic [VL_W-1:0] vl;
        logic            halted;
    } state_t;

    state_t   st_d, st_q;
    verdict_t v_cond, v_ldst, v_sel;
    variant_e variant;
    logic     accept;
    logic [VL_W-1:0] idx_ext;

    ff_cond_test #(.CR_W(CR_W), .SEL_W(SEL_W)) u_cond (
        .cond_field (cond_field),
        .bit_sel    (bit_sel),
        .invert     (invert),
        .inclusive  (inclusive),
        .suppress   (suppress),
        .verdict    (v_cond)
    );

    ff_ldst_check #(.IDX_W(IDX_W)) u_ldst (
        .elem_idx   (elem_idx),
        .elem_fault (elem_fault),
        .verdict    (v_ldst)
    );

    always_comb begin
        variant  = variant_e'(ldst_mode);
        v_sel    = (variant == VAR_LDST) ? v_ldst : v_cond;
        idx_ext  = VL_W'(elem_idx);
        accept   = elem_valid && !loop_start && !st_q.halted && (idx_ext < st_q.vl);

        stop_o     = accept && v_sel.fail;
        store_en_o = accept && v_sel.keep;
        exc_o      = accept && v_sel.exc;

        st_d = st_q;
        if (loop_start) begin
            st_d.vl     = vl_init;
            st_d.halted = 1'b0;
        end else if (stop_o) begin
            st_d.vl     = idx_ext + (v_sel.incl ? VL_W'(1) : VL_W'(0));
            st_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_o = st_q.vl;

    // R3
    ldst_vl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && ldst_mode) |=> (vl_o != '0));

    // R10
    vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_o && !loop_start) |=> $stable(vl_o));

    // R11
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R7
    suppress_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldst_mode && suppress) |-> !store_en_o);

    // R1
    first_fault_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> $stable(vl_o));

endmodule

// File: tb/ff_trunc_unit_tb.sv
module ff_trunc_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 8;
    localparam int CR_W   = 4;
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int SEL_W  = $clog2(CR_W);

    logic clk = 1'b0;
    logic rst_n;
    logic loop_start, ldst_mode, elem_valid, elem_fault, invert, inclusive, suppress;
    logic [VL_W-1:0]  vl_init;
    logic [IDX_W-1:0] elem_idx;
    logic [CR_W-1:0]  cond_field;
    logic [SEL_W-1:0] bit_sel;
    logic [VL_W-1:0]  vl_o;
    logic stop_o, store_en_o, exc_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ff_trunc_unit #(.MAX_VL(MAX_VL), .CR_W(CR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .loop_start(loop_start), .vl_init(vl_init),
        .ldst_mode(ldst_mode), .elem_valid(elem_valid), .elem_idx(elem_idx),
        .elem_fault(elem_fault), .cond_field(cond_field), .bit_sel(bit_sel),
        .invert(invert), .inclusive(inclusive), .suppress(suppress),
        .vl_o(vl_o), .stop_o(stop_o), .store_en_o(store_en_o), .exc_o(exc_o)
    );

    typedef struct {
        logic            st;
        logic            stp;
        logic            ex;
        logic [VL_W-1:0] vl;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state built from the requirements
    int m_vl   = 0;
    bit m_halt = 1'b0;

    task automatic drive(input bit st, input int vi, input bit ld, input bit v,
                         input int idx, input bit ex, input logic [CR_W-1:0] cr,
                         input int sel, input bit iv, input bit incl, input bit sup,
                         input string tag);
        exp_t e;
        bit acc, fail, keep, excp, inc_eff;
        @(negedge clk);
        loop_start = st; vl_init = VL_W'(vi); ldst_mode = ld; elem_valid = v;
        elem_idx = IDX_W'(idx); elem_fault = ex; cond_field = cr; bit_sel = SEL_W'(sel);
        invert = iv; inclusive = incl; suppress = sup;
        acc = v && !st && !m_halt && (idx < m_vl);
        if (ld) begin
            fail = ex && (idx != 0);
            excp = ex && (idx == 0);
            keep = !ex;
            inc_eff = 1'b0;
        end else begin
            fail = (cr[sel] == iv);
            excp = 1'b0;
            inc_eff = incl && !sup;
            keep = !sup && (!fail || inc_eff);
        end
        e.st = acc && keep; e.stp = acc && fail; e.ex = acc && excp;
        e.vl = VL_W'(m_vl); e.tag = tag;
        exp_q.push_back(e);
        if (st) begin
            m_vl = vi; m_halt = 1'b0;
        end else if (acc && fail) begin
            m_vl = idx + (inc_eff ? 1 : 0); m_halt = 1'b1;
        end
    endtask

    task automatic start_loop(input int vi, input bit ld, input string tag);
        drive(1'b1, vi, ld, 1'b0, 0, 1'b0, '0, 0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic cond_elem(input int idx, input logic [CR_W-1:0] cr, input int sel,
                             input bit iv, input bit incl, input bit sup, input string tag);
        drive(1'b0, 0, 1'b0, 1'b1, idx, 1'b0, cr, sel, iv, incl, sup, tag);
    endtask

    task automatic ls_elem(input int idx, input bit ex, input bit incl, input string tag);
        drive(1'b0, 0, 1'b1, 1'b1, idx, ex, '0, 0, 1'b0, incl, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, '0, 0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: samples a quarter period after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (store_en_o !== e.st || stop_o !== e.stp || exc_o !== e.ex || vl_o !== e.vl) begin
                    fails++;
                    $display("FAIL %s: got store=%0b stop=%0b exc=%0b vl=%0d, expected store=%0b stop=%0b exc=%0b vl=%0d",
                             e.tag, store_en_o, stop_o, exc_o, vl_o, e.st, e.stp, e.ex, e.vl);
                end
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        loop_start = 0; vl_init = '0; ldst_mode = 0; elem_valid = 0; elem_idx = '0;
        elem_fault = 0; cond_field = '0; bit_sel = '0; invert = 0; inclusive = 0; suppress = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R10 reset state");

        // R9: full-length loop, every element passes
        start_loop(8, 1'b0, "R10 start");
        for (int i = 0; i < 8; i++) cond_elem(i, 4'b0100, 2, 1'b0, 1'b0, 1'b0, "R9 pass");
        idle("R9 length kept");

        // R4 R5: exclusive failure on bit 1 at element 2
        start_loop(8, 1'b0, "R10 start");
        cond_elem(0, 4'b0000, 1, 1'b1, 1'b0, 1'b0, "R4 pass");
        cond_elem(1, 4'b1101, 1, 1'b1, 1'b0, 1'b0, "R4 pass bit1 clear");
        cond_elem(2, 4'b0010, 1, 1'b1, 1'b0, 1'b0, "R4 fail");
        cond_elem(3, 4'b0000, 1, 1'b1, 1'b0, 1'b0, "R11 after stop");
        idle("R5 exclusive length");

        // R5: inclusive failure on bit 0
        start_loop(6, 1'b0, "R10 start");
        cond_elem(0, 4'b0001, 0, 1'b0, 1'b1, 1'b0, "R4 pass");
        cond_elem(3, 4'b1110, 0, 1'b0, 1'b1, 1'b0, "R5 inclusive fail");
        idle("R5 inclusive length");

        // R6: zero length from element 0
        start_loop(5, 1'b0, "R10 start");
        cond_elem(0, 4'b1000, 3, 1'b1, 1'b0, 1'b0, "R6 first fails");
        cond_elem(1, 4'b0000, 3, 1'b1, 1'b0, 1'b0, "R6 silenced");
        cond_elem(0, 4'b0000, 3, 1'b1, 1'b0, 1'b0, "R11 zero length");

        // R7 R8: suppress with inclusive requested
        start_loop(5, 1'b0, "R10 start");
        cond_elem(0, 4'b0000, 2, 1'b1, 1'b1, 1'b1, "R7 pass no store");
        cond_elem(1, 4'b0000, 2, 1'b1, 1'b1, 1'b1, "R7 pass no store");
        cond_elem(2, 4'b0100, 2, 1'b1, 1'b1, 1'b1, "R8 fail exclusive");
        idle("R8 length");

        // R1 R2: memory-access variant
        start_loop(8, 1'b1, "R10 start");
        ls_elem(0, 1'b1, 1'b0, "R1 first fault");
        ls_elem(1, 1'b0, 1'b0, "R2 no fault");
        ls_elem(2, 1'b1, 1'b0, "R2 later fault");
        ls_elem(3, 1'b1, 1'b0, "R11 after stop");
        idle("R2 length");

        // R3: inclusive flag ignored, length stays nonzero
        start_loop(4, 1'b1, "R10 start");
        ls_elem(1, 1'b1, 1'b1, "R3 fault at 1");
        idle("R3 length");

        // R11: index at the length and element in the start cycle
        start_loop(3, 1'b0, "R10 start");
        cond_elem(3, 4'b0000, 0, 1'b0, 1'b0, 1'b0, "R11 index past length");
        drive(1'b1, 2, 1'b0, 1'b1, 0, 1'b0, 4'b0000, 0, 1'b0, 1'b0, 1'b0, "R11 start cycle");
        idle("R10 reload");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule